// File: doc/BRIEF.md
# 2-D Convolution MAC Engine

This block is the arithmetic core of a 2-D image filter. Before each frame it takes in one signed 8-bit coefficient per kernel tap over a byte-wide stream. It then accepts one complete kernel-sized window of unsigned 8-bit pixels per clock. For every window it forms all tap products at once and reduces them in a registered adder tree. It multiplies the sum by an unsigned fixed-point gain, rounds the result, adds a signed offset and clamps it to an 8-bit pixel. Windows are built upstream, and memory traffic is handled elsewhere.

A frame holds width × height windows, with both dimensions at least one. The frame dimensions, the gain and the offset are sampled when the last coefficient of a load is taken. The gain and offset then stay fixed until the next load. The coefficient stream is held off until every result of the previous frame has left the block. One global stall, driven by the output handshake, freezes every pipeline register at once. The fixed input-to-output delay is published as the localparam `LATENCY` = 3 + ceil(log2(taps)).

Top module: `conv_mac_engine`

## Requirements
- R1: Window tap i sits at `win_data[8i+7:8i]`, numbered row-major (i = row × KW + column). It is multiplied by the i-th coefficient byte accepted in the load, counting from zero. All tap products are summed with no overflow.
- R2: In the load phase `coef_ready` is high whenever no result is still in flight. After exactly KH × KW accepted coefficient bytes the block enters the run phase: `coef_ready` drops and `win_ready` rises.
- R3: The sum is multiplied by `cfg_scale`, an unsigned value with 16 fractional bits. It is rounded to the nearest integer, and an exact half rounds toward plus infinity, so the result is floor(sum × scale / 65536 + 0.5).
- R4: The signed 16-bit `cfg_bias` is added to the rounded value.
- R5: The final value is clamped: below 0 gives 0 and above 255 gives 255, with no wrap.
- R6: A frame accepts exactly width × height windows, and its last result carries `out_last`. After that window the block returns to the load phase. `out_last` is never high without `out_valid`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pixel` and `out_last` hold their values. Results leave in order, and none is lost or repeated.
- R8: With `out_ready` held high, a window accepted before clock edge n gives its result after edge n + LATENCY − 1. Consecutive windows give results on consecutive cycles.
- R9: Windows offered in the load phase are not taken (`win_ready` low), and coefficient bytes offered in the run phase are not taken (`coef_ready` low). Neither changes any result.
- R10: After synchronous reset `out_valid` is low and the block is in the load phase with `win_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 16 | Windows per row, sampled at the last coefficient |
| cfg_height | input | 16 | Rows per frame, sampled at the last coefficient |
| cfg_scale | input | 24 | Unsigned gain, 16 fractional bits |
| cfg_bias | input | 16 | Signed offset added after rounding |
| coef_valid | input | 1 | Coefficient byte offered |
| coef_ready | output | 1 | Coefficient byte taken this cycle when valid |
| coef_data | input | 8 | Signed coefficient |
| win_valid | input | 1 | Window offered |
| win_ready | output | 1 | Window taken this cycle when valid |
| win_data | input | 8·KH·KW | Packed pixel window, tap i at bits 8i+7:8i |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_pixel | output | 8 | Clamped result pixel |
| out_last | output | 1 | Result is the final one of the frame |

## Verification
The bench uses a 3×3 kernel so that the sums stay small enough to reproduce exactly with wide integers. Exact-half sums are driven with a gain of one half and with both positive and negative coefficients. A design that truncates, or that rounds half away from zero, gives results one off on negative ties. Extreme coefficients, gains and offsets push the result far past both clamp limits, which exposes any wrap to a small value. Random output stalls, junk coefficient bytes during a frame and windows offered during the load phase check that stalled data is held, that nothing is dropped or duplicated, and that no extra transfer is taken. A one-window frame and a cycle-counted frame catch an off-by-one in the frame count, a misplaced `out_last`, or a latency or throughput that differs from the published figure.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PIX_W   = 8;
    localparam int COEF_W  = 8;
    localparam int SCALE_W = 24;
    localparam int FRAC_W  = 16;
    localparam int BIAS_W  = 16;
    localparam int DIM_W   = 16;

    typedef enum logic {PH_LOAD, PH_RUN} phase_e;

    // Valid/frame-end marker carried next to the data in every stage
    typedef struct packed {
        logic vld;
        logic last;
    } tag_t;

    function automatic int tree_levels(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    // Signed product of an unsigned pixel and a signed coefficient, plus tree growth
    function automatic int acc_width(input int n);
        return PIX_W + COEF_W + 1 + tree_levels(n);
    endfunction

    // Product register + one register per tree level + gain stage + clamp stage
    function automatic int pipe_latency(input int n);
        return 1 + tree_levels(n) + 2;
    endfunction
endpackage

// File: rtl/conv_coef_ctrl.sv
module conv_coef_ctrl
    import conv_mac_pkg::*;
#(
    parameter int NTAPS = 225,
    parameter int LAT   = 11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DIM_W-1:0]         cfg_width,
    input  logic [DIM_W-1:0]         cfg_height,
    input  logic [SCALE_W-1:0]       cfg_scale,
    input  logic signed [BIAS_W-1:0] cfg_bias,
    input  logic                     coef_valid,
    input  logic [COEF_W-1:0]        coef_data,
    output logic                     coef_ready,
    input  logic                     win_valid,
    input  logic                     adv,
    output logic                     win_ready,
    output tag_t                     win_tag,
    input  logic                     out_fire,
    output logic [NTAPS*COEF_W-1:0]  coef_flat,
    output logic [SCALE_W-1:0]       scale_q,
    output logic signed [BIAS_W-1:0] bias_q
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = (NTAPS > 1) ? $clog2(NTAPS) : 1;
    localparam int TOT_W = 2 * DIM_W;
    localparam int FL_W  = $clog2(LAT + 2);

    phase_e             phase;
    logic [CNT_W-1:0]   tap_cnt;
    logic [TOT_W-1:0]   total_q;
    logic [TOT_W-1:0]   win_cnt;
    logic [FL_W-1:0]    inflight;
    logic [COEF_W-1:0]  coef_q [NTAPS];

    logic coef_fire, win_fire, last_tap, frame_end;

    assign last_tap   = (tap_cnt == CNT_W'(NTAPS - 1));
    assign frame_end  = (win_cnt == total_q - TOT_W'(1));
    assign coef_ready = (phase == PH_LOAD) && (inflight == '0);
    assign win_ready  = (phase == PH_RUN) && adv;
    assign coef_fire  = coef_valid && coef_ready;
    assign win_fire   = win_valid && win_ready;
    assign win_tag    = '{vld: win_fire, last: frame_end};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_LOAD;
            tap_cnt  <= '0;
            win_cnt  <= '0;
            total_q  <= '0;
            inflight <= '0;
            scale_q  <= '0;
            bias_q   <= '0;
        end else begin
            if (coef_fire) begin
                if (last_tap) begin
                    tap_cnt <= '0;
                    phase   <= PH_RUN;
                    total_q <= cfg_width * cfg_height;
                    scale_q <= cfg_scale;
                    bias_q  <= cfg_bias;
                end else begin
                    tap_cnt <= tap_cnt + CNT_W'(1);
                end
            end
            if (win_fire) begin
                if (frame_end) begin
                    win_cnt <= '0;
                    phase   <= PH_LOAD;
                end else begin
                    win_cnt <= win_cnt + TOT_W'(1);
                end
            end
            case ({win_fire, out_fire})
                2'b10:   inflight <= inflight + FL_W'(1);
                2'b01:   inflight <= inflight - FL_W'(1);
                default: inflight <= inflight;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (coef_fire) coef_q[tap_cnt] <= coef_data;
    end

    for (genvar t = 0; t < NTAPS; t++) begin : g_coef_out
        assign coef_flat[t*COEF_W +: COEF_W] = coef_q[t];
    end

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
        inflight <= FL_W'(LAT)) else $error("more results in flight than pipeline stages"); // R8

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) |-> (win_cnt < total_q)) else $error("window count past frame size"); // R6

    AST_FULL_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_RUN) |-> ($past(coef_fire) && $past(last_tap))) else $error("run entered before full load"); // R2
endmodule

// File: rtl/conv_sum_tree.sv
module conv_sum_tree
    import conv_mac_pkg::*;
#(
    parameter int NTAPS = 225,
    parameter int ACC_W = acc_width(225)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv,
    input  tag_t                       tag_i,
    input  logic [NTAPS*PIX_W-1:0]     pix_i,
    input  logic [NTAPS*COEF_W-1:0]    coef_i,
    output logic signed [ACC_W-1:0]    sum_o,
    output tag_t                       tag_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LVL = tree_levels(NTAPS);
    localparam int NP  = 1 << LVL;

    logic [NP*PIX_W-1:0]  pix_pad;
    logic [NP*COEF_W-1:0] coef_pad;

    assign pix_pad  = {{((NP - NTAPS) * PIX_W + 1){1'b0}}, pix_i} [NP*PIX_W-1:0];
    assign coef_pad = {{((NP - NTAPS) * COEF_W + 1){1'b0}}, coef_i} [NP*COEF_W-1:0];

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int W = NP >> l;
        logic signed [ACC_W-1:0] node [W];
        tag_t                    tag;

        if (l == 0) begin : g_leaf
            always_ff @(posedge clk) begin
                if (rst)      tag <= '0;
                else if (adv) tag <= tag_i;
            end
            for (genvar i = 0; i < W; i++) begin : g_mul
                logic signed [ACC_W-1:0] pe, ce;
                assign pe = ACC_W'($signed({1'b0, pix_pad[i*PIX_W +: PIX_W]}));
                assign ce = ACC_W'($signed(coef_pad[i*COEF_W +: COEF_W]));
                always_ff @(posedge clk) begin
                    if (adv) node[i] <= pe * ce;
                end
            end
        end else begin : g_add
            always_ff @(posedge clk) begin
                if (rst)      tag <= '0;
                else if (adv) tag <= g_lvl[l-1].tag;
            end
            for (genvar i = 0; i < W; i++) begin : g_sum
                always_ff @(posedge clk) begin
                    if (adv) node[i] <= g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
                end
            end
        end
    end

    assign sum_o = g_lvl[LVL].node[0];
    assign tag_o = g_lvl[LVL].tag;
endmodule

// File: rtl/conv_post.sv
module conv_post
    import conv_mac_pkg::*;
#(
    parameter int ACC_W = acc_width(225)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  logic signed [ACC_W-1:0]  sum_i,
    input  tag_t                     tag_i,
    input  logic [SCALE_W-1:0]       scale_i,
    input  logic signed [BIAS_W-1:0] bias_i,
    output logic [PIX_W-1:0]         pix_o,
    output tag_t                     tag_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MUL_W = ACC_W + SCALE_W + 1;
    localparam logic signed [MUL_W-1:0] HALF    = MUL_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [MUL_W-1:0] PIX_MAX = MUL_W'((1 << PIX_W) - 1);

    logic signed [MUL_W-1:0] mul_q, rnd, biased;
    logic [PIX_W-1:0]        clamp;
    tag_t                    tag_a;

    // Stage A: gain
    always_ff @(posedge clk) begin
        if (rst)      tag_a <= '0;
        else if (adv) tag_a <= tag_i;
        if (adv) mul_q <= MUL_W'(sum_i) * MUL_W'($signed({1'b0, scale_i}));
    end

    // Round half up, offset, clamp
    always_comb begin
        rnd    = (mul_q + HALF) >>> FRAC_W;
        biased = rnd + MUL_W'(bias_i);
        if (biased < 0)             clamp = '0;
        else if (biased > PIX_MAX)  clamp = '1;
        else                        clamp = biased[PIX_W-1:0];
    end

    // Stage B: result register
    always_ff @(posedge clk) begin
        if (rst)      tag_o <= '0;
        else if (adv) tag_o <= tag_a;
        if (adv) pix_o <= clamp;
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (adv && tag_a.vld && (biased > PIX_MAX)) |=> (pix_o == '1)) else $error("high clamp missed"); // R5

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (adv && tag_a.vld && (biased < 0)) |=> (pix_o == '0)) else $error("low clamp missed"); // R5
endmodule

// File: rtl/conv_mac_engine.sv
module conv_mac_engine
    import conv_mac_pkg::*;
#(
    parameter int KH = 15,
    parameter int KW = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DIM_W-1:0]         cfg_width,
    input  logic [DIM_W-1:0]         cfg_height,
    input  logic [SCALE_W-1:0]       cfg_scale,
    input  logic signed [BIAS_W-1:0] cfg_bias,
    input  logic                     coef_valid,
    output logic                     coef_ready,
    input  logic [COEF_W-1:0]        coef_data,
    input  logic                     win_valid,
    output logic                     win_ready,
    input  logic [KH*KW*PIX_W-1:0]   win_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [PIX_W-1:0]         out_pixel,
    output logic                     out_last
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NTAPS   = KH * KW;
    localparam int ACC_W   = acc_width(NTAPS);
    localparam int LATENCY = pipe_latency(NTAPS);

    logic                       adv;
    tag_t                       in_tag, sum_tag, out_tag;
    logic [NTAPS*COEF_W-1:0]    coef_flat;
    logic [SCALE_W-1:0]         scale_q;
    logic signed [BIAS_W-1:0]   bias_q;
    logic signed [ACC_W-1:0]    sum;

    // One stall for all stages: advance when the output slot is free or being taken
    assign adv       = out_ready || !out_tag.vld;
    assign out_valid = out_tag.vld;
    assign out_last  = out_tag.vld && out_tag.last;

    conv_coef_ctrl #(.NTAPS(NTAPS), .LAT(LATENCY)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .cfg_scale  (cfg_scale),
        .cfg_bias   (cfg_bias),
        .coef_valid (coef_valid),
        .coef_data  (coef_data),
        .coef_ready (coef_ready),
        .win_valid  (win_valid),
        .adv        (adv),
        .win_ready  (win_ready),
        .win_tag    (in_tag),
        .out_fire   (out_valid && out_ready),
        .coef_flat  (coef_flat),
        .scale_q    (scale_q),
        .bias_q     (bias_q)
    );

    conv_sum_tree #(.NTAPS(NTAPS), .ACC_W(ACC_W)) i_tree (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .tag_i  (in_tag),
        .pix_i  (win_data),
        .coef_i (coef_flat),
        .sum_o  (sum),
        .tag_o  (sum_tag)
    );

    conv_post #(.ACC_W(ACC_W)) i_post (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .sum_i   (sum),
        .tag_i   (sum_tag),
        .scale_i (scale_q),
        .bias_i  (bias_q),
        .pix_o   (out_pixel),
        .tag_o   (out_tag)
    );

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_last)))
        else $error("stalled result changed"); // R7

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(coef_ready && win_ready)) else $error("both streams ready"); // R9

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid) else $error("frame end without result"); // R6
endmodule

// File: tb/test_conv_mac_engine.sv
module test_conv_mac_engine;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int KH  = 3;
    localparam int KW  = 3;
    localparam int NT  = KH * KW;
    localparam int EXP_LAT = 3 + 4;   // product + ceil(log2 9) tree levels + gain + clamp

    logic        clk = 0;
    logic        rst;
    logic [15:0] cfg_width, cfg_height;
    logic [23:0] cfg_scale;
    logic [15:0] cfg_bias;
    logic        coef_valid, coef_ready;
    logic [7:0]  coef_data;
    logic        win_valid, win_ready;
    logic [NT*8-1:0] win_data;
    logic        out_valid, out_ready, out_last;
    logic [7:0]  out_pixel;

    conv_mac_engine #(.KH(KH), .KW(KW)) i_conv_mac_engine (
        .clk(clk), .rst(rst),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_scale(cfg_scale), .cfg_bias(cfg_bias),
        .coef_valid(coef_valid), .coef_ready(coef_ready), .coef_data(coef_data),
        .win_valid(win_valid), .win_ready(win_ready), .win_data(win_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel), .out_last(out_last)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int     coefs [NT];
    longint gain;
    int     offs;

    int  exp_pix [$];
    bit  exp_last [$];
    string exp_req [$];

    bit       prev_stall = 0;
    logic [7:0] prev_pix;
    int first_acc, first_out, last_out, last_seen;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int model(input logic [NT*8-1:0] w);
        longint s = 0;
        longint v;
        for (int i = 0; i < NT; i++) s += longint'(w[i*8 +: 8]) * longint'(coefs[i]);
        v = ((s * gain) + 32768) >>> 16;
        v = v + offs;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return int'(v);
    endfunction

    function automatic logic [NT*8-1:0] make_win(input int mode);
        logic [NT*8-1:0] w;
        for (int i = 0; i < NT; i++) begin
            case (mode)
                1: w[i*8 +: 8] = 8'd255;
                2: w[i*8 +: 8] = 8'd0;
                3: w[i*8 +: 8] = 8'($urandom % 4);
                default: w[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return w;
    endfunction

    // Observe the output side after inputs for the coming edge are settled
    task automatic watch_out();
        if (prev_stall) begin
            check(out_valid === 1'b1 && out_pixel === prev_pix, "R7 stall hold", out_pixel, prev_pix);
        end
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pixel;
        if (out_valid && out_ready) begin
            if (exp_pix.size() == 0) begin
                check(0, "R7 unexpected result", out_pixel, -1);
            end else begin
                int e = exp_pix.pop_front();
                bit l = exp_last.pop_front();
                string r = exp_req.pop_front();
                check(out_pixel === 8'(e), r, out_pixel, e);
                check(out_last === l, "R6 out_last", out_last, l);
                if (first_out < 0) first_out = cyc;
                last_out = cyc;
                if (out_last) last_seen++;
            end
        end
    endtask

    task automatic load_coefs(input int w, input int h, input longint sc, input int bi);
        int idx = 0;
        cfg_width  = 16'(w);
        cfg_height = 16'(h);
        cfg_scale  = 24'(sc);
        cfg_bias   = 16'(bi);
        gain = sc;
        offs = bi;
        while (idx < NT) begin
            @(negedge clk); cyc++;
            out_ready  = 1;
            win_valid  = 0;
            coef_valid = ($urandom % 4) != 0;
            coef_data  = 8'(coefs[idx]);
            #1;
            if (coef_valid && coef_ready) idx++;
            watch_out();
        end
        @(negedge clk); cyc++;
        coef_valid = 0;
        #1;
        check(coef_ready === 1'b0 && win_ready === 1'b1, "R2 run phase after full load", {coef_ready, win_ready}, 2'b01);
        watch_out();
    endtask

    task automatic run_frame(input int w, input int h, input bit rnd_ready, input bit gaps,
                             input int pmode, input bit junk, input string req);
        int total = w * h;
        int sent  = 0;
        logic [NT*8-1:0] cur = make_win(pmode);
        first_acc = -1; first_out = -1; last_seen = 0;
        while (sent < total || exp_pix.size() != 0) begin
            @(negedge clk); cyc++;
            out_ready  = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
            win_valid  = (sent < total) && (!gaps || (($urandom % 4) != 0));
            win_data   = cur;
            coef_valid = junk;
            coef_data  = 8'($urandom);
            #1;
            if (junk) check(coef_ready === 1'b0, "R9 coefficient refused in run", coef_ready, 0);
            if (win_valid && win_ready) begin
                exp_pix.push_back(model(cur));
                exp_last.push_back(sent == total - 1);
                exp_req.push_back(req);
                if (first_acc < 0) first_acc = cyc;
                sent++;
                cur = make_win(pmode);
            end
            watch_out();
        end
        @(negedge clk); cyc++;
        win_valid = 0; coef_valid = 0; out_ready = 1;
        #1;
        check(last_seen == 1, "R6 one frame end per frame", last_seen, 1);
        check(coef_ready === 1'b1 && win_ready === 1'b0, "R6 back to load phase", {coef_ready, win_ready}, 2'b10);
        watch_out();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; coef_valid = 0; coef_data = 0; win_valid = 0; win_data = '0; out_ready = 1;
        cfg_width = 1; cfg_height = 1; cfg_scale = 0; cfg_bias = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); cyc++;
        #1;
        check(out_valid === 1'b0, "R10 no result after reset", out_valid, 0);
        check(coef_ready === 1'b1 && win_ready === 1'b0, "R10 load phase after reset", {coef_ready, win_ready}, 2'b10);

        // R9: windows offered while loading are refused and produce nothing
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); cyc++;
            win_valid = 1; win_data = make_win(0);
            #1;
            check(win_ready === 1'b0 && out_valid === 1'b0, "R9 window refused in load", {win_ready, out_valid}, 0);
        end
        win_valid = 0;

        // R1/R8: mixed coefficients, unit gain, full rate
        coefs = '{3, -2, 5, 0, 7, -8, 1, 4, -1};
        load_coefs(4, 3, 65536, 0);
        run_frame(4, 3, 0, 0, 0, 0, "R1 sum of products");
        check(first_out - first_acc == EXP_LAT, "R8 latency", first_out - first_acc, EXP_LAT);
        check(last_out - first_out == 11, "R8 one result per cycle", last_out - first_out, 11);

        // R3: positive half ties with gain one half, stalls and junk coefficients
        coefs = '{1, 1, 1, 1, 1, 1, 1, 1, 1};
        load_coefs(5, 2, 32768, 0);
        run_frame(5, 2, 1, 1, 3, 1, "R3 round half up");

        // R3/R4: negative half ties, positive offset
        coefs = '{-1, -1, -1, -1, -1, -1, -1, -1, -1};
        load_coefs(4, 4, 32768, 20);
        run_frame(4, 4, 1, 0, 3, 1, "R4 offset after rounding");

        // R5: extreme coefficients and gain, negative offset
        coefs = '{127, -128, 127, -128, 127, -128, 127, -128, -128};
        load_coefs(3, 3, 3*65536 + 12345, -300);
        run_frame(3, 3, 1, 1, 0, 0, "R5 clamp mixed");

        // R5: saturate high
        coefs = '{127, 127, 127, 127, 127, 127, 127, 127, 127};
        load_coefs(2, 1, 65536, 32767);
        run_frame(2, 1, 1, 0, 1, 0, "R5 clamp high");

        // R5/R6: saturate low, one-window frame
        coefs = '{-128, -128, -128, -128, -128, -128, -128, -128, -128};
        load_coefs(1, 1, 24'hFFFFFF, -32768);
        run_frame(1, 1, 0, 0, 1, 0, "R5 clamp low");

        // R1: zero pixels with offset only, then random sweep with fractional gain
        coefs = '{9, 8, 7, 6, 5, 4, 3, 2, 1};
        load_coefs(2, 2, 65536, 77);
        run_frame(2, 2, 0, 0, 2, 0, "R1 zero window");
        coefs = '{-3, 6, -9, 12, -15, 18, -21, 24, -27};
        load_coefs(8, 6, 40000, 128);
        run_frame(8, 6, 1, 1, 0, 1, "R1 random sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule